// File: doc/BRIEF.md
# Transmit Frame Padder and CRC-32 Appender

This block sits in the transmit path between the stage that produces frame bytes and the MAC serializer. Frames enter and leave as byte-wide valid/ready streams, and a marker flags the final byte of each frame. Two configuration inputs control it. `pad_en` turns on padding to the minimum length. `fcs_dis` suppresses the frame check sequence.

When padding is on, a frame with fewer than 60 data bytes is followed by zero bytes. After the pad, the block computes a CRC-32 over every byte sent so far, pad included, and appends it. The frame then leaves at exactly 64 bytes. Padding forces the CRC to be appended even if `fcs_dis` is set. With padding off, `fcs_dis` alone decides whether a CRC follows the data. With padding off and `fcs_dis` set, frames pass through untouched.

A small state machine has three states:
- `ST_DATA` passes source bytes through.
- `ST_PAD` emits zero bytes.
- `ST_FCS` emits the four CRC bytes.

The transitions are:
- `ST_DATA` to `ST_PAD`: the last source byte is accepted with padding on and fewer than 60 bytes sent.
- `ST_DATA` to `ST_FCS`: the last source byte is accepted with a CRC due and no pad needed.
- `ST_PAD` to `ST_FCS`: the 60th byte is accepted.
- `ST_FCS` to `ST_DATA`: the fourth CRC byte is accepted.
- `ST_DATA` to `ST_DATA`: the frame end is accepted with no CRC due.

Top module: `padfcs_tx`

## Requirements
- R1: With `pad_en`=0 and `fcs_dis`=1, each output byte equals the corresponding input byte, and `m_last` is asserted only with the input's last byte, so the frame leaves unchanged.
- R2: With `pad_en`=1, a frame of N<60 data bytes is followed by 60-N bytes of value 0x00, and then by the FCS, so that exactly 64 bytes leave.
- R3: With `pad_en`=1, a frame of 60 or more data bytes receives no pad bytes.
- R4: The FCS is the CRC-32 with reflected polynomial 0xEDB88320 (normal form 0x04C11DB7), initial value 0xFFFFFFFF and final inversion. It covers all data and pad bytes, follows the pad, and is sent least significant byte first, with `m_last` on its fourth byte.
- R5: With `pad_en`=1, the FCS is appended even when `fcs_dis`=1.
- R6: With `pad_en`=0 and `fcs_dis`=0, the FCS follows the data directly, with no pad bytes.
- R7: While `m_valid`=1 and `m_ready`=0 during pad or FCS output, `m_data` and `m_last` hold; no byte is lost or duplicated under any backpressure pattern.
- R8: In the cycle after the last input byte of a frame that needs a pad or an FCS is accepted, `s_ready` is 0. It stays 0 until the frame's final byte has left.
- R9: After reset, `m_valid` is 0 while no input is offered, and the CRC starts fresh for every frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pad_en | input | 1 | Enable padding to minimum length (forces FCS) |
| fcs_dis | input | 1 | Suppress FCS when padding is off |
| s_data | input | 8 | Input byte |
| s_valid | input | 1 | Input byte valid |
| s_last | input | 1 | Input byte is the last of its frame |
| s_ready | output | 1 | Block accepts the input byte |
| m_data | output | 8 | Output byte |
| m_valid | output | 1 | Output byte valid |
| m_last | output | 1 | Output byte is the last of its frame |
| m_ready | input | 1 | Downstream accepts the output byte |

## Verification
Two events can fall in the same cycle. The first is the generation of a pad or CRC byte, with its CRC update or shift. The second is a downstream stall that must freeze that byte. A similar collision occurs when the last source byte arrives while the output is stalled. The bench provokes both by drawing `m_ready` at random each cycle with a per-frame acceptance rate, while the input inserts random gaps. Directed frames of 1, 59, 60 and 61 bytes cover the points where padding starts and stops. Each collected output frame is compared byte for byte, with its final-byte marker, against a frame and CRC that the bench builds on its own.

// File: rtl/padfcs_pkg.sv
package padfcs_pkg;

    typedef enum logic [1:0] {
        ST_DATA,
        ST_PAD,
        ST_FCS
    } pf_state_t;

    localparam logic [31:0] CRC_POLY_REFL = 32'hEDB8_8320;

    // One byte through the reflected CRC-32 register, low bit first.
    function automatic logic [31:0] crc32_byte(input logic [31:0] c, input logic [7:0] d);
        logic [31:0] r;
        r = c ^ {24'h0, d};
        for (int b = 0; b < 8; b++) begin
            r = r[0] ? ((r >> 1) ^ CRC_POLY_REFL) : (r >> 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/padfcs_crc.sv
module padfcs_crc
    import padfcs_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        upd,
    input  logic        shift,
    input  logic [7:0]  din,
    output logic [31:0] crc_q
);
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            crc_q <= '1;
        end else if (upd) begin
            crc_q <= crc32_byte(crc_q, din);
        end else if (shift) begin
            crc_q <= {8'hFF, crc_q[31:8]};
        end
    end
endmodule

// File: rtl/padfcs_len.sv
module padfcs_len #(
    parameter int LIMIT = 60
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic full_after
);
    localparam int W = $clog2(LIMIT + 1);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (inc && (cnt_q != W'(LIMIT))) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // True when the byte now being counted brings the frame to the limit.
    assign full_after = (cnt_q >= W'(LIMIT - 1));
endmodule

// File: rtl/padfcs_tx.sv
module padfcs_tx
    import padfcs_pkg::*;
#(
    parameter int MIN_FRAME = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pad_en,
    input  logic       fcs_dis,
    input  logic [7:0] s_data,
    input  logic       s_valid,
    input  logic       s_last,
    output logic       s_ready,
    output logic [7:0] m_data,
    output logic       m_valid,
    output logic       m_last,
    input  logic       m_ready
);
    localparam int FCS_BYTES = 4;
    localparam int PAD_TO    = MIN_FRAME - FCS_BYTES;
    localparam int IDX_W     = $clog2(FCS_BYTES);

    pf_state_t        state, state_nx;
    logic [IDX_W-1:0] idx_q;
    logic [31:0]      crc_q;
    logic             full_after;
    logic             gen_fcs;
    logic             out_hs;
    logic             crc_upd, crc_shift, frame_end;
    logic             idx_last;

    assign gen_fcs   = pad_en || !fcs_dis;
    assign out_hs    = m_valid && m_ready;
    assign idx_last  = (idx_q == IDX_W'(FCS_BYTES - 1));
    assign crc_upd   = out_hs && (state != ST_FCS);
    assign crc_shift = out_hs && (state == ST_FCS);
    assign frame_end = out_hs && m_last;

    padfcs_crc u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (frame_end),
        .upd   (crc_upd),
        .shift (crc_shift),
        .din   (m_data),
        .crc_q (crc_q)
    );

    padfcs_len #(.LIMIT(PAD_TO)) u_len (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (frame_end),
        .inc        (crc_upd),
        .full_after (full_after)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_DATA: begin
                if (out_hs && s_last && gen_fcs) begin
                    state_nx = (pad_en && !full_after) ? ST_PAD : ST_FCS;
                end
            end
            ST_PAD: begin
                if (out_hs && full_after) state_nx = ST_FCS;
            end
            ST_FCS: begin
                if (out_hs && idx_last) state_nx = ST_DATA;
            end
            default: state_nx = ST_DATA;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_DATA;
            idx_q <= '0;
        end else begin
            state <= state_nx;
            if (crc_shift) begin
                idx_q <= idx_last ? '0 : idx_q + 1'b1;
            end
        end
    end

    always_comb begin
        s_ready = 1'b0;
        m_valid = 1'b1;
        m_data  = 8'h00;
        m_last  = 1'b0;
        unique case (state)
            ST_DATA: begin
                s_ready = m_ready;
                m_valid = s_valid;
                m_data  = s_data;
                m_last  = s_last && !gen_fcs;
            end
            ST_PAD: begin
                m_data = 8'h00;
            end
            ST_FCS: begin
                m_data = ~crc_q[7:0];
                m_last = idx_last;
            end
            default: begin
                m_valid = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/padfcs_tx_chk.sv
module padfcs_tx_chk
    import padfcs_pkg::*;
#(
    parameter int MIN_FRAME = 64
) (
    input logic       clk,
    input logic       rst_n,
    input logic       pad_en,
    input logic       fcs_dis,
    input logic       s_valid,
    input logic       s_last,
    input logic       s_ready,
    input logic [7:0] m_data,
    input logic       m_valid,
    input logic       m_last,
    input logic       m_ready,
    input pf_state_t  state
);
    logic [15:0] obytes;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            obytes <= '0;
        end else if (m_valid && m_ready) begin
            obytes <= m_last ? 16'd0 : ((obytes == 16'hFFFF) ? obytes : obytes + 16'd1);
        end
    end

    AST_PASS_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (!pad_en && fcs_dis && s_valid && s_ready) |-> (m_last == s_last)); // R1

    AST_PAD_MIN_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && m_ready && m_last && pad_en) |-> (obytes >= 16'(MIN_FRAME - 1))); // R2

    AST_FCS_NOT_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && s_ready && s_last && pad_en) |-> !m_last); // R5

    AST_GEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_DATA && m_valid && !m_ready) |=>
            (m_valid && $stable(m_data) && $stable(m_last))); // R7

    AST_INTAKE_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && s_ready && s_last && (pad_en || !fcs_dis)) |=> !s_ready); // R8

    AST_GEN_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_DATA) |-> m_valid); // R7
endmodule

bind padfcs_tx padfcs_tx_chk #(.MIN_FRAME(MIN_FRAME)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .pad_en  (pad_en),
    .fcs_dis (fcs_dis),
    .s_valid (s_valid),
    .s_last  (s_last),
    .s_ready (s_ready),
    .m_data  (m_data),
    .m_valid (m_valid),
    .m_last  (m_last),
    .m_ready (m_ready),
    .state   (state)
);

// File: tb/padfcs_tx_test.sv
module padfcs_tx_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pad_en = 1'b0;
    logic       fcs_dis = 1'b1;
    logic [7:0] s_data = 8'h00;
    logic       s_valid = 1'b0;
    logic       s_last = 1'b0;
    logic       s_ready;
    logic [7:0] m_data;
    logic       m_valid;
    logic       m_last;
    logic       m_ready = 1'b0;

    int checks = 0;
    int errors = 0;
    int frames_out = 0;
    int ready_pct = 100;
    bit done = 1'b0;

    logic [7:0] got_d[$];
    logic       got_l[$];
    logic [7:0] exp_d[$];
    logic [7:0] src[$];

    always #2 clk = ~clk;

    padfcs_tx uut (
        .clk(clk), .rst_n(rst_n), .pad_en(pad_en), .fcs_dis(fcs_dis),
        .s_data(s_data), .s_valid(s_valid), .s_last(s_last), .s_ready(s_ready),
        .m_data(m_data), .m_valid(m_valid), .m_last(m_last), .m_ready(m_ready)
    );

    function automatic logic [31:0] ref_crc(input logic [7:0] q[$]);
        logic [31:0] c = 32'hFFFF_FFFF;
        foreach (q[i]) begin
            for (int b = 0; b < 8; b++) begin
                logic fb;
                fb = c[0] ^ q[i][b];
                c = c >> 1;
                if (fb) c = c ^ 32'hEDB8_8320;
            end
        end
        return ~c;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Downstream model: random ready, byte capture mid-cycle.
    always begin
        @(negedge clk);
        m_ready = rst_n && (($urandom % 100) < ready_pct);
        #1;
        if (rst_n && m_valid && m_ready) begin
            got_d.push_back(m_data);
            got_l.push_back(m_last);
            if (m_last) frames_out++;
        end
    end

    task automatic run_frame(input int len, input bit pe, input bit fd, input int rp);
        bit gen;
        int target;
        int pads;
        string tag;
        logic [31:0] c;
        int bad;
        @(negedge clk);
        pad_en = pe;
        fcs_dis = fd;
        ready_pct = rp;
        gen = pe || !fd;
        src.delete();
        exp_d.delete();
        got_d.delete();
        got_l.delete();
        for (int i = 0; i < len; i++) src.push_back(8'($urandom));
        foreach (src[i]) exp_d.push_back(src[i]);
        pads = 0;
        if (pe) while (exp_d.size() < 60) begin exp_d.push_back(8'h00); pads++; end
        if (gen) begin
            c = ref_crc(exp_d);
            for (int k = 0; k < 4; k++) exp_d.push_back(c[8*k +: 8]);
        end
        target = frames_out + 1;
        for (int i = 0; i < len; i++) begin
            repeat ($urandom % 3) begin
                @(negedge clk);
                s_valid = 1'b0;
            end
            @(negedge clk);
            s_valid = 1'b1;
            s_data = src[i];
            s_last = (i == len - 1);
            #1;
            while (!s_ready) begin
                @(negedge clk);
                #1;
            end
            @(posedge clk);
        end
        @(negedge clk);
        s_valid = 1'b0;
        s_last = 1'b0;
        #1;
        if (gen) check(s_ready == 1'b0, "R8", "s_ready after last input", s_ready, 0);
        while (frames_out < target) @(negedge clk);
        @(negedge clk);
        tag = pe ? (len < 60 ? "R2" : "R3") : (fd ? "R1" : "R6");
        check(got_d.size() == exp_d.size(), tag, "frame length", got_d.size(), exp_d.size());
        bad = -1;
        for (int i = 0; i < got_d.size() && i < exp_d.size(); i++)
            if (bad < 0 && got_d[i] !== exp_d[i]) bad = i;
        check(bad < 0, tag, "byte mismatch index", bad, -1);
        if (gen) begin
            c = 32'h0;
            if (got_d.size() >= 4)
                for (int k = 0; k < 4; k++) c[8*k +: 8] = got_d[got_d.size() - 4 + k];
            check(c == ref_crc(exp_d[0:exp_d.size()-5]), (pe && fd) ? "R5" : "R4",
                  "fcs value", int'(c), int'(ref_crc(exp_d[0:exp_d.size()-5])));
        end
        bad = -1;
        foreach (got_l[i]) if (got_l[i] !== (i == got_l.size() - 1)) bad = i;
        check(bad < 0, "R9", "m_last position", bad, -1);
        if (rp < 60) check(got_d.size() == exp_d.size(), "R7", "count under backpressure",
                           got_d.size(), exp_d.size());
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check(m_valid == 1'b0, "R9", "m_valid after reset", m_valid, 0);
        run_frame(1,   1, 0, 100);  // R2 shortest
        run_frame(59,  1, 1, 50);   // R2, R5
        run_frame(60,  1, 1, 40);   // R3 boundary, R7
        run_frame(61,  1, 0, 70);   // R3
        run_frame(10,  0, 1, 30);   // R1 passthrough, R7
        run_frame(10,  0, 0, 100);  // R6
        run_frame(100, 0, 0, 25);   // R6, R7
        run_frame(5,   1, 1, 20);   // R5 heavy stall
        for (int f = 0; f < 40; f++) begin
            run_frame(1 + ($urandom % 90), 1'($urandom), 1'($urandom), 10 + ($urandom % 91));
        end
        finish_run();
    end
endmodule